// File: doc/BRIEF.md
# Serial Pattern Detector with Permanent Lockout

This block watches a one-bit serial stream and raises a detect flag when the last three accepted bits were 0, 1, 0 in that order, oldest first. It only does this while the stream has never contained 1, 0, 0 since the last reset. As soon as that pattern arrives, the machine falls into a halt state. It stays in that state whatever the input does, and only a synchronous reset brings it back.

The stream moves one bit at a time. A bit counts only in a cycle where `bit_valid` is high. There is no back-pressure: the block is always ready, so every valid bit is consumed on the rising edge where it is presented. In cycles without a valid bit the state is held. The current state number is driven on `state_code` so that a debug probe or a bench can follow the machine. The detect flag depends on the state alone (Moore style), so it rises on the clock edge that accepts the final 0 of 010.

Top module: `seqdet_lockout`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is S0 (`state_code` = 0) and `detect` is 0.
- R2: A rising edge with `rst` low and `bit_valid` low leaves `state_code` and `detect` unchanged.
- R3: On an accepted bit, the state moves as follows.
  - From S0: 0 goes to S1 and 1 goes to S4.
  - From S1: 0 stays in S1 and 1 goes to S2.
  - From S2: 0 goes to S3 and 1 goes to S4.
  - From S3: 0 goes to S6 and 1 goes to S2.
  - From S4: 0 goes to S5 and 1 stays in S4.
  - From S5: 0 goes to S6 and 1 goes to S2.
- R4: `detect` is 1 exactly when the machine is in S3, that is, right after 010 has been accepted with no earlier 100.
- R5: Accepting 100 puts the machine in S6, the halt state. From S6 an accepted 0 or 1 leaves it in S6 with `detect` at 0.
- R6: `state_code` is the state index as a 3-bit unsigned binary number (S0 = 0 through S6 = 6). The value 7 never appears.
- R7: Reset wins over a valid bit in the same cycle.
- R8: Reset is the only way out of S6. A reset taken in S6 returns the machine to S0, and detection then works again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Accepts `bit_in` on this edge (step enable) |
| bit_in | input | 1 | Serial data bit |
| detect | output | 1 | High while in the detect state S3 |
| state_code | output | 3 | Current state index, for observation |

## Verification
The hardest arcs to reach are the ones that leave S6 and the exits from S3 and S5. Each of them needs a particular history first, and the lockout blocks any later attempt. The bench therefore resets before every arc, walks a shortest prefix to the source state and applies each input value once. It then runs a long pseudo-random stream with gaps in `bit_valid` and occasional resets against an arithmetic model of the machine.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 3'd0,
    ST_Z     = 3'd1,
    ST_ZO    = 3'd2,
    ST_HIT   = 3'd3,
    ST_O     = 3'd4,
    ST_OZ    = 3'd5,
    ST_HALT  = 3'd6
  } seq_state_t;
endpackage

// File: rtl/seqdet_next.sv
module seqdet_next
  import seqdet_pkg::*;
(
  input  seq_state_t cur,
  input  logic       din,
  output seq_state_t nxt
);
  always_comb begin
    unique case (cur)
      ST_IDLE: nxt = din ? ST_O  : ST_Z;
      ST_Z:    nxt = din ? ST_ZO : ST_Z;
      ST_ZO:   nxt = din ? ST_O  : ST_HIT;
      ST_HIT:  nxt = din ? ST_ZO : ST_HALT;
      ST_O:    nxt = din ? ST_O  : ST_OZ;
      ST_OZ:   nxt = din ? ST_ZO : ST_HALT;
      default: nxt = ST_HALT;
    endcase
  end
endmodule

// File: rtl/seqdet_state_reg.sv
module seqdet_state_reg
  import seqdet_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  seq_state_t d,
  output seq_state_t q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= ST_IDLE;
    else if (step) q <= d;
  end
endmodule

// File: rtl/seqdet_out.sv
module seqdet_out
  import seqdet_pkg::*;
(
  input  seq_state_t cur,
  output logic       hit,
  output logic [STATE_W-1:0] code
);
  assign hit  = (cur == ST_HIT);
  assign code = STATE_W'(cur);
endmodule

// File: rtl/seqdet_lockout.sv
module seqdet_lockout
  import seqdet_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_valid,
  input  logic               bit_in,
  output logic               detect,
  output logic [2:0]         state_code
);
  seq_state_t cur_st;
  seq_state_t nxt_st;

  seqdet_next u_next (
    .cur (cur_st),
    .din (bit_in),
    .nxt (nxt_st)
  );

  seqdet_state_reg u_reg (
    .clk  (clk),
    .rst  (rst),
    .step (bit_valid),
    .d    (nxt_st),
    .q    (cur_st)
  );

  seqdet_out u_out (
    .cur  (cur_st),
    .hit  (detect),
    .code (state_code)
  );
endmodule

// File: rtl/seqdet_lockout_chk.sv
module seqdet_lockout_chk (
  input logic       clk,
  input logic       rst,
  input logic       bit_valid,
  input logic       bit_in,
  input logic       detect,
  input logic [2:0] state_code
);
  // R1 / R7: reset wins, even with a valid bit present
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (state_code == 3'd0 && !detect));

  // R2: no valid bit, no movement
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> ($stable(state_code) && $stable(detect)));

  // R4: detect can only start after an accepted 0
  p_detect_src_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(detect) |-> ($past(bit_valid) && !$past(bit_in)));

  // R4: detect state comes only from S2
  p_detect_pred_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(detect) |-> ($past(state_code) == 3'd2));

  // R5: entering halt from S5 on a 0
  p_enter_halt_r5: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd5 && bit_valid && !bit_in) |=> (state_code == 3'd6));

  // R5 / R8: halt is absorbing without reset
  p_halt_stays_r8: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd6) |=> (state_code == 3'd6 && !detect));

  // R6: code stays within range
  p_code_range_r6: assert property (@(posedge clk) disable iff (rst)
    state_code != 3'd7);
endmodule

bind seqdet_lockout seqdet_lockout_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_valid  (bit_valid),
  .bit_in     (bit_in),
  .detect     (detect),
  .state_code (state_code)
);

// File: tb/seqdet_lockout_tb.sv
module seqdet_lockout_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b0;
  logic       detect;
  logic [2:0] state_code;

  int checks = 0;
  int errors = 0;
  int model  = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  seqdet_lockout u_dut (
    .clk        (clk),
    .rst        (rst),
    .bit_valid  (bit_valid),
    .bit_in     (bit_in),
    .detect     (detect),
    .state_code (state_code)
  );

  // Reference model built from the R3/R5 table
  function automatic int ref_next(input int s, input logic b);
    case (s)
      0: return b ? 4 : 1;
      1: return b ? 2 : 1;
      2: return b ? 4 : 3;
      3: return b ? 2 : 6;
      4: return b ? 4 : 5;
      5: return b ? 2 : 6;
      default: return 6;
    endcase
  endfunction

  task automatic check(input string req);
    logic exp_det;
    exp_det = (model == 3);
    checks++;
    if (int'(state_code) != model || detect != exp_det) begin
      errors++;
      $display("FAIL %s: state=%0d detect=%0b expected state=%0d detect=%0b",
               req, state_code, detect, model, exp_det);
    end
  endtask

  task automatic tick(input logic r, input logic v, input logic b, input string req);
    rst = r; bit_valid = v; bit_in = b;
    @(posedge clk);
    if (r)      model = 0;
    else if (v) model = ref_next(model, b);
    @(negedge clk);
    check(req);
  endtask

  task automatic walk(input int target);
    case (target)
      1: tick(0, 1, 0, "R3");
      2: begin tick(0, 1, 0, "R3"); tick(0, 1, 1, "R3"); end
      3: begin tick(0, 1, 0, "R3"); tick(0, 1, 1, "R3"); tick(0, 1, 0, "R4"); end
      4: tick(0, 1, 1, "R3");
      5: begin tick(0, 1, 1, "R3"); tick(0, 1, 0, "R3"); end
      6: begin tick(0, 1, 1, "R3"); tick(0, 1, 0, "R3"); tick(0, 1, 0, "R5"); end
      default: ;
    endcase
  endtask

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    tick(1, 0, 0, "R1");
    tick(1, 1, 1, "R7");

    // Every arc: reset, walk to source, apply each bit
    for (int s = 0; s < 7; s++) begin
      for (int b = 0; b < 2; b++) begin
        tick(1, 0, 0, "R1");
        walk(s);
        tick(0, 0, b[0], "R2");
        tick(0, 1, b[0], (s == 6) ? "R5" : "R3");
        checks++;
        if (state_code == 3'd7) begin
          errors++;
          $display("FAIL R6: state=%0d expected 0..6", state_code);
        end
      end
    end

    // Halt survives many inputs, only reset clears it (R8)
    tick(1, 0, 0, "R1");
    walk(6);
    for (int i = 0; i < 8; i++) tick(0, 1, i[0], "R8");
    tick(1, 1, 0, "R8");
    walk(3);
    tick(0, 0, 0, "R2");

    // Long random stream with gaps and occasional resets
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick((lfsr[7:0] == 8'h3C), lfsr[3] | lfsr[9], lfsr[0], "R3");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule